// File: doc/BRIEF.md
# Phase-Accumulator PWM Generator

This block produces a single pulse-width-modulated output from a 16-bit phase accumulator. A clock divider emits a one-cycle beat strobe every `clkDiv+1` clocks. On each beat the accumulator grows by a step of 2^(15-res), where `res` is the duty resolution. One pulse cycle therefore holds 2^(res+1) beats and ends when the accumulator wraps back to zero modulo 2^16.

The output sits at its active level while the phase is below the duty word. The duty word first has the bits below the step size cleared. The `invert` input turns the active level from high to low. The duty word and the resolution are captured into shadow registers only when the accumulator wraps, or while the block is disabled, so a pulse cycle is never cut short or stretched by a change made in the middle of it. When `enable` is low the phase holds at zero, the divider restarts, and the output rests at its inactive level.

Top module: `pwm_phase_gen`

## Requirements
- R1: While reset is asserted, `phase` reads 0. With `enable` low and `invert` low, `pwmOut` reads 0.
- R2: While enabled, the phase changes exactly once every `clkDiv+1` clocks. The first change comes `clkDiv+1` clocks after `enable` rises.
- R3: Each phase change adds 2^(15-res) modulo 2^16, so a pulse cycle contains exactly 2^(res+1) changes and the last one lands on 0.
- R4: The pulse period, measured between successive entries of `phase` into 0, is (clkDiv+1)*2^(res+1) clocks. The active portion comes first, so the output is active at the start of a cycle whenever the active count is nonzero.
- R5: The output is active while `phase` is below the duty word with bits [14-res:0] cleared. That gives (clkDiv+1)*(duty>>(15-res)) active clocks per period.
- R6: A duty word of 16'h0000 keeps the output inactive for the whole period. A duty word of 16'hFFFF keeps it active for the whole period.
- R7: With `invert` high, the active level is 0 and the inactive level is 1. With `invert` low, the active level is 1.
- R8: A change to the duty word or the resolution made while enabled has no effect until `phase` next wraps to 0. The cycle after the wrap follows the new values.
- R9: With `enable` low, `phase` is 0 from the next clock on, `pwmOut` equals `invert`, and new duty and resolution values apply from the moment `enable` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run control; low holds phase at zero |
| resolution | input | 4 | Duty resolution; cycle has 2^(res+1) beats |
| dutyCycle | input | 16 | Duty threshold compared against phase |
| clkDiv | input | 16 | Beat strobe every clkDiv+1 clocks |
| invert | input | 1 | Swaps active and inactive output levels |
| pwmOut | output | 1 | PWM output |
| phase | output | 16 | Current phase accumulator value |

## Verification
The bench aims at the duty extremes 0 and 16'hFFFF. A design without the full-scale special case would drop the output for the final beat of every cycle. The bench also uses duty words whose low bits lie below the step size; a missing mask would add a partial beat, visible as a wrong active-clock count. A mid-cycle change of duty and resolution checks that the old threshold governs every clock up to the wrap, since loading immediately would reshape the running pulse. Measured periods and step deltas across several dividers catch an off-by-one in the beat strobe.

// File: rtl/pwm_phase_pkg.sv
package pwm_phase_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic beat;   // advance phase by one step
    logic clear;  // hold phase at zero (block disabled)
    logic load;   // capture new duty/resolution into shadows
  } ctrlStrobes_t;
endpackage

// File: rtl/pwm_phase_ctrl.sv
module pwm_phase_ctrl
  import pwm_phase_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic             wrapNext,
  output ctrlStrobes_t     strobes
);
  logic [DIV_W-1:0] divCnt;
  logic             divDone;

  assign divDone = (divCnt >= clkDiv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divCnt <= '0;
    end else if (!enable || divDone) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.beat  = enable && divDone;
    strobes.clear = !enable;
    strobes.load  = !enable || (enable && divDone && wrapNext);
  end
endmodule

// File: rtl/pwm_phase_dp.sv
module pwm_phase_dp
  import pwm_phase_pkg::*;
#(
  parameter int PHASE_W = 16,
  parameter int RES_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctrlStrobes_t       strobes,
  input  logic [RES_W-1:0]   resIn,
  input  logic [PHASE_W-1:0] dutyIn,
  input  logic               invert,
  output logic               wrapNext,
  output logic               pwmOut,
  output logic [PHASE_W-1:0] phase
);
  localparam int MAXRES = PHASE_W - 1;

  logic [RES_W-1:0]   resQ, resEff, shiftAmt;
  logic [PHASE_W-1:0] dutyQ, phaseQ, stepW, maskW;
  logic [PHASE_W:0]   sumW;
  logic               active;

  always_comb begin
    resEff   = (resQ > RES_W'(MAXRES)) ? RES_W'(MAXRES) : resQ;
    shiftAmt = RES_W'(MAXRES) - resEff;
    stepW    = PHASE_W'(1) << shiftAmt;
    maskW    = ~(stepW - PHASE_W'(1));
    sumW     = {1'b0, phaseQ} + {1'b0, stepW};
    wrapNext = sumW[PHASE_W];
    active   = (dutyQ == '1) || (phaseQ < (dutyQ & maskW));
    pwmOut   = (!strobes.clear && active) ^ invert;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phaseQ <= '0;
      dutyQ  <= '0;
      resQ   <= '0;
    end else begin
      if (strobes.clear)     phaseQ <= '0;
      else if (strobes.beat) phaseQ <= sumW[PHASE_W-1:0];
      if (strobes.load) begin
        dutyQ <= dutyIn;
        resQ  <= resIn;
      end
    end
  end

  assign phase = phaseQ;
endmodule

// File: rtl/pwm_phase_gen.sv
module pwm_phase_gen
  import pwm_phase_pkg::*;
#(
  parameter int PHASE_W = 16,
  parameter int RES_W   = 4,
  parameter int DIV_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [RES_W-1:0]   resolution,
  input  logic [PHASE_W-1:0] dutyCycle,
  input  logic [DIV_W-1:0]   clkDiv,
  input  logic               invert,
  output logic               pwmOut,
  output logic [PHASE_W-1:0] phase
);
  ctrlStrobes_t strobes;
  logic         wrapNext;

  pwm_phase_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .clkDiv(clkDiv),
    .wrapNext(wrapNext), .strobes(strobes)
  );

  pwm_phase_dp #(.PHASE_W(PHASE_W), .RES_W(RES_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .resIn(resolution),
    .dutyIn(dutyCycle), .invert(invert), .wrapNext(wrapNext),
    .pwmOut(pwmOut), .phase(phase)
  );
endmodule

// File: rtl/pwm_phase_chk.sv
module pwm_phase_chk #(
  parameter int PHASE_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               enable,
  input logic               invert,
  input logic               pwmOut,
  input logic [PHASE_W-1:0] phase
);
  // R9: disabled block holds phase at zero from the next clock
  p_idle_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (phase == '0));

  // R9 / R7: disabled output rests at the inactive level
  p_idle_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (pwmOut == invert));

  // R3: every phase movement while running is a single power-of-two step
  p_step_pow2_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && (phase != $past(phase)))
      |-> ($countones(PHASE_W'(phase - $past(phase))) == 1));

  // R3: the phase only ever decreases by wrapping exactly to zero
  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && (phase < $past(phase))) |-> (phase == '0));
endmodule

bind pwm_phase_gen pwm_phase_chk #(.PHASE_W(PHASE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .invert(invert),
  .pwmOut(pwmOut), .phase(phase)
);

// File: tb/pwm_phase_gen_tb.sv
module pwm_phase_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [3:0]  resolution = '0;
  logic [15:0] dutyCycle = '0;
  logic [15:0] clkDiv = '0;
  logic        invert = 1'b0;
  logic        pwmOut;
  logic [15:0] phase;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  pwm_phase_gen u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .resolution(resolution),
    .dutyCycle(dutyCycle), .clkDiv(clkDiv), .invert(invert),
    .pwmOut(pwmOut), .phase(phase)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expPeriod(input int res, input int div);
    return (div + 1) * (1 << (res + 1));
  endfunction

  function automatic int expActive(input int res, input logic [15:0] duty, input int div);
    if (duty == 16'hFFFF) return expPeriod(res, div);
    return (div + 1) * int'(duty >> (15 - res));
  endfunction

  // Advance to the sample where phase has just wrapped into zero
  task automatic waitWrap();
    logic [15:0] prev;
    int guard = 0;
    do begin
      prev = phase;
      @(negedge clk);
      guard++;
    end while (!(prev != 0 && phase == 0) && guard < 70000);
  endtask

  // Called at a wrap sample; measures one full period and checks it
  task automatic measure(input int res, input logic [15:0] duty, input int div, input bit inv);
    logic [15:0] prev, prevWas, step;
    int n = 0, act = 0, ch = 0, bad = 0;
    bit firstActive;
    step = 16'(1 << (15 - res));
    firstActive = (pwmOut != inv);
    prev = phase;
    do begin
      n++;
      act += (pwmOut != inv) ? 1 : 0;
      @(negedge clk);
      if (phase != prev) begin
        ch++;
        if (16'(phase - prev) != step) bad++;
      end
      prevWas = prev;
      prev = phase;
    end while (!(phase == 0 && prevWas != 0) && n < 70000);
    check(n == expPeriod(res, div), "R4 R2 period", n, expPeriod(res, div));
    check(ch == (1 << (res + 1)), "R3 beat count", ch, 1 << (res + 1));
    check(bad == 0, "R3 step size", bad, 0);
    check(act == expActive(res, duty, div), "R5 R6 R7 active clocks",
          act, expActive(res, duty, div));
    check(firstActive == (expActive(res, duty, div) > 0), "R4 R7 active first",
          int'(firstActive), int'(expActive(res, duty, div) > 0));
  endtask

  task automatic runConfig(input int res, input logic [15:0] duty, input int div, input bit inv);
    @(negedge clk);
    enable = 1'b0;
    resolution = 4'(res);
    dutyCycle = duty;
    clkDiv = 16'(div);
    invert = inv;
    @(negedge clk);
    @(negedge clk);
    check(phase == 0, "R9 idle phase", phase, 0);
    check(pwmOut == inv, "R9 R7 idle level", pwmOut, inv);
    enable = 1'b1;
    waitWrap();
    measure(res, duty, div, inv);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(phase == 0, "R1 reset phase", phase, 0);
    check(pwmOut == 0, "R1 reset output", pwmOut, 0);
    rst_n = 1'b1;

    // R2: first beat comes clkDiv+1 clocks after enable
    @(negedge clk);
    resolution = 4'd2; dutyCycle = 16'h8000; clkDiv = 16'd2;
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk); @(negedge clk);
    check(phase == 0, "R2 no early beat", phase, 0);
    @(negedge clk);
    check(phase == 16'h2000, "R2 first beat", phase, 16'h2000);

    // Directed corner cases
    runConfig(0, 16'h8000, 0, 1'b0);
    runConfig(2, 16'h3FFF, 1, 1'b0);  // R5 masking of low bits
    runConfig(5, 16'h0000, 2, 1'b1);  // R6 zero duty, inverted
    runConfig(3, 16'hFFFF, 0, 1'b0);  // R6 full scale
    runConfig(3, 16'hFFFF, 1, 1'b1);  // R6 R7 full scale inverted
    runConfig(9, 16'h1234, 0, 1'b0);

    // R8: mid-cycle change deferred until wrap
    runConfig(3, 16'h8000, 1, 1'b0);
    begin
      int mism = 0, guard = 0;
      while (phase != 16'h4000 && guard < 1000) begin @(negedge clk); guard++; end
      dutyCycle = 16'h4000;
      resolution = 4'd1;
      while (phase != 0 && guard < 2000) begin
        if (pwmOut != (phase < 16'h8000)) mism++;
        @(negedge clk);
        guard++;
      end
      check(mism == 0, "R8 old duty kept until wrap", mism, 0);
      measure(1, 16'h4000, 1, 1'b0);
    end

    // Constrained random configurations
    for (int i = 0; i < 20; i++) begin
      int res = int'($urandom_range(7, 0));
      int div = int'($urandom_range(3, 0));
      int sel = int'($urandom_range(7, 0));
      logic [15:0] duty = 16'($urandom);
      if (sel == 0) duty = 16'h0000;
      if (sel == 1) duty = 16'hFFFF;
      runConfig(res, duty, div, 1'($urandom));
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule